// File: doc/BRIEF.md
# Dual-Compare Toggle Timer

This block is one channel of a general-purpose timer. A 16-bit counter counts upward by one on each count-enable tick while the channel is running. Four compare registers watch the counter. Two of them (the A and C compare values) each invert output pin A on a match, and the other two (B and D) each invert output pin B. With two compare values per pin, a single counter period places two edges of the designer's choosing on each pin, so a pulse of any position and width can be produced without software help.

Software drives the channel through a simple write port: one address per compare value, one control word, and one flag-clear word. The control word starts and stops counting, optionally makes a match on compare A clear the counter (period of A+1 ticks), optionally stops the channel after an A match, loads the starting level of each pin, masks each pin, and can zero the counter. Each compare value has a sticky match flag that stays set until software clears it.

Top module: `dual_toggle_timer`

## Requirements
- R1: After reset the counter is 0, all four flags are 0, both pins are low, every compare value is FFFFH and the control word is 0 (stopped, both pins enabled).
- R2: While the run bit (control bit 0) is 1, each cycle with `tick` high adds one to the counter; without clear-on-A the counter goes from FFFFH to 0000H. Ticks while the run bit is 0 change nothing.
- R3: With clear-on-A (control bit 1) set, a tick on which the counter equals compare A makes the next counter value 0000H, giving a period of A+1 ticks.
- R4: Pin A's state inverts after a running tick on which the counter equals compare A (address 0) or compare C (address 2); when both match on the same tick it inverts once only.
- R5: Pin B's state inverts after a running tick on which the counter equals compare B (address 1) or compare D (address 3); when both match on the same tick it inverts once only.
- R6: Any write to the control word (address 4) loads pin A's state from bit 3 and pin B's state from bit 4 of the written value; the state holds until the next compare event.
- R7: A running tick on which the counter equals compare A, B, C or D sets flag bit 0, 1, 2 or 3 respectively. A flag stays set until a write to address 5 carries 0 in that bit; a 1 leaves it unchanged; when a match and a clear hit the same flag in one cycle, the flag ends set.
- R8: Control bit 5 (pin A) and bit 6 (pin B) are active-low enables: a 1 forces that pin low while its internal state keeps toggling, and clearing the bit shows the current state again.
- R9: With stop-on-A (control bit 2) set, a running tick that matches compare A clears the run bit after that tick's own counter update; with bit 2 clear the channel keeps running.
- R10: A write to a compare value takes effect for the very next tick, with no buffering.
- R11: Writing the control word with bit 7 set zeroes the counter in that cycle; bit 7 is not stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count-enable pulse, one count per high cycle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address: 0..3 compare A..D, 4 control, 5 flag clear |
| wrData | input | 16 | Write data |
| count | output | 16 | Current counter value |
| pinA | output | 1 | Output pin A |
| pinB | output | 1 | Output pin B |
| flags | output | 4 | Sticky match flags, bit 0..3 for compare A..D |

## Verification
The toggling outputs are tried with compare values spread across a cleared period, so each pin shows two separate edges per period and a misrouted compare shows as a wrong edge position. A pattern with compare C equal to compare A tells a single inversion from a double one, and a sparse tick pattern tells ticks apart from clock cycles. A free-running pass through FFFFH separates wrapping from clearing, a stop-on-A run separates stopping from continuing, and flag clears written every cycle across matches show whether a set wins over a clear.

// File: rtl/dtt_pkg.sv
package dtt_pkg;

  localparam int unsigned NUM_CMP = 4;

  // register addresses
  localparam int unsigned REG_CTRL = 4;
  localparam int unsigned REG_FLAG = 5;

  // control word bit positions
  localparam int unsigned CB_RUN  = 0;
  localparam int unsigned CB_CLRA = 1;
  localparam int unsigned CB_STOP = 2;
  localparam int unsigned CB_INIA = 3;
  localparam int unsigned CB_INIB = 4;
  localparam int unsigned CB_DISA = 5;
  localparam int unsigned CB_DISB = 6;
  localparam int unsigned CB_ZERO = 7;

  // strobes from control to datapath
  typedef struct packed {
    logic               advance;
    logic               zeroCnt;
    logic               loadInit;
    logic               initA;
    logic               initB;
    logic               clrOnA;
    logic [NUM_CMP-1:0] cmpWe;
  } dtt_strobe_t;

endpackage

// File: rtl/dtt_ctrl.sv
module dtt_ctrl
  import dtt_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [7:0]         wrByte,
  input  logic [NUM_CMP-1:0] hitVec,
  output dtt_strobe_t        strobe,
  output logic               disA,
  output logic               disB,
  output logic [NUM_CMP-1:0] flags
);

  logic ctrlWr;
  logic flagWr;
  logic runBit;
  logic clrOnA;
  logic stopOnA;
  logic [NUM_CMP-1:0] clearVec;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_W'(REG_CTRL));
  assign flagWr   = wrEn && (wrAddr == ADDR_W'(REG_FLAG));
  assign clearVec = flagWr ? ~wrByte[NUM_CMP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      runBit  <= 1'b0;
      clrOnA  <= 1'b0;
      stopOnA <= 1'b0;
      disA    <= 1'b0;
      disB    <= 1'b0;
    end else if (ctrlWr) begin
      runBit  <= wrByte[CB_RUN];
      clrOnA  <= wrByte[CB_CLRA];
      stopOnA <= wrByte[CB_STOP];
      disA    <= wrByte[CB_DISA];
      disB    <= wrByte[CB_DISB];
    end else if (stopOnA && hitVec[0]) begin
      runBit  <= 1'b0;
    end
  end

  // hardware set wins over software clear
  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clearVec) | hitVec;
  end

  always_comb begin
    strobe.advance  = tick && runBit;
    strobe.zeroCnt  = ctrlWr && wrByte[CB_ZERO];
    strobe.loadInit = ctrlWr;
    strobe.initA    = wrByte[CB_INIA];
    strobe.initB    = wrByte[CB_INIB];
    strobe.clrOnA   = clrOnA;
  end

  generate
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_we
      assign strobe.cmpWe[i] = wrEn && (wrAddr == ADDR_W'(i));
    end
  endgenerate

  // R7: a match always leaves its flag set
  a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
    hitVec[1] |=> flags[1]);

  // R7: a set flag survives unless cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags[2] && !clearVec[2]) |=> flags[2]);

  // R9: stop-on-A drops the run state
  a_r9_stop: assert property (@(posedge clk) disable iff (rst)
    (stopOnA && hitVec[0] && !ctrlWr) |=> !strobe.advance);

endmodule

// File: rtl/dtt_datapath.sv
module dtt_datapath
  import dtt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  dtt_strobe_t        strobe,
  input  logic [CNT_W-1:0]   wrData,
  output logic [NUM_CMP-1:0] hitVec,
  output logic [CNT_W-1:0]   count,
  output logic               togA,
  output logic               togB
);

  logic [CNT_W-1:0]   cmpReg [NUM_CMP];
  logic [NUM_CMP-1:0] matchVec;
  logic               evA;
  logic               evB;

  generate
    for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
      always_ff @(posedge clk) begin
        if (rst)                  cmpReg[i] <= '1;
        else if (strobe.cmpWe[i]) cmpReg[i] <= wrData;
      end
      assign matchVec[i] = (count == cmpReg[i]);
      assign hitVec[i]   = matchVec[i] && strobe.advance;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                          count <= '0;
    else if (strobe.zeroCnt)          count <= '0;
    else if (strobe.advance) begin
      if (strobe.clrOnA && hitVec[0]) count <= '0;
      else                            count <= count + 1'b1;
    end
  end

  // a pin inverts once even if both of its compares match
  assign evA = hitVec[0] | hitVec[2];
  assign evB = hitVec[1] | hitVec[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      togA <= 1'b0;
      togB <= 1'b0;
    end else if (strobe.loadInit) begin
      togA <= strobe.initA;
      togB <= strobe.initB;
    end else begin
      if (evA) togA <= ~togA;
      if (evB) togB <= ~togB;
    end
  end

  // R2: counter idle without a running tick
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    (!strobe.advance && !strobe.zeroCnt) |=> $stable(count));

  // R3: clear on compare A
  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && strobe.clrOnA && matchVec[0] && !strobe.zeroCnt) |=> (count == '0));

  // R4: single inversion of pin A per event
  a_r4_single_toggle: assert property (@(posedge clk) disable iff (rst)
    (evA && !strobe.loadInit) |=> (togA != $past(togA)));

  // R5: pin B holds without an event
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!evB && !strobe.loadInit) |=> $stable(togB));

endmodule

// File: rtl/dual_toggle_timer.sv
module dual_toggle_timer
  import dtt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CNT_W-1:0]   wrData,
  output logic [CNT_W-1:0]   count,
  output logic               pinA,
  output logic               pinB,
  output logic [NUM_CMP-1:0] flags
);

  dtt_strobe_t        strobe;
  logic [NUM_CMP-1:0] hitVec;
  logic               disA;
  logic               disB;
  logic               togA;
  logic               togB;

  dtt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrByte (wrData[7:0]),
    .hitVec (hitVec),
    .strobe (strobe),
    .disA   (disA),
    .disB   (disB),
    .flags  (flags)
  );

  dtt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .wrData (wrData),
    .hitVec (hitVec),
    .count  (count),
    .togA   (togA),
    .togB   (togB)
  );

  assign pinA = disA ? 1'b0 : togA;
  assign pinB = disB ? 1'b0 : togB;

  // R8: a masked pin stays low
  a_r8_mask: assert property (@(posedge clk) disable iff (rst)
    disA |-> !pinA);

endmodule

// File: tb/sim_dual_toggle_timer.sv
module sim_dual_toggle_timer;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] count;
  logic        pinA;
  logic        pinB;
  logic [3:0]  flags;

  always #5 clk = ~clk;

  dual_toggle_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .count(count), .pinA(pinA), .pinB(pinB), .flags(flags)
  );

  typedef struct packed {
    logic [15:0] cnt;
    logic        pa;
    logic        pb;
    logic [3:0]  fl;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  int    vectors = 0;
  int    fails   = 0;
  bit    done    = 1'b0;

  // reference state, from the requirements
  logic [15:0] mCount = '0;
  logic [15:0] mCmp [4] = '{16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF};
  logic [3:0]  mFlags = '0;
  logic        mRun = 0, mClr = 0, mStop = 0, mDisA = 0, mDisB = 0;
  logic        mTogA = 0, mTogB = 0;

  task automatic step(input logic tk, input logic we, input logic [2:0] ad,
                      input logic [15:0] dt, input string tag);
    logic [3:0] hit;
    logic adv, ctrlW, flagW;
    exp_t e;
    @(negedge clk);
    tick = tk; wrEn = we; wrAddr = ad; wrData = dt;
    adv   = tk && mRun;
    ctrlW = we && (ad == 3'd4);
    flagW = we && (ad == 3'd5);
    for (int i = 0; i < 4; i++) hit[i] = adv && (mCount == mCmp[i]);
    if (ctrlW && dt[7])          mCount = '0;
    else if (adv) mCount = (mClr && hit[0]) ? 16'h0 : mCount + 16'h1;
    if (ctrlW) begin
      mTogA = dt[3]; mTogB = dt[4];
    end else begin
      if (hit[0] || hit[2]) mTogA = ~mTogA;
      if (hit[1] || hit[3]) mTogB = ~mTogB;
    end
    if (ctrlW) begin
      mRun = dt[0]; mClr = dt[1]; mStop = dt[2]; mDisA = dt[5]; mDisB = dt[6];
    end else if (mStop && hit[0]) mRun = 1'b0;
    mFlags = (flagW ? (mFlags & dt[3:0]) : mFlags) | hit;
    if (we && ad < 3'd4) mCmp[ad[1:0]] = dt;
    e.cnt = mCount;
    e.pa  = mDisA ? 1'b0 : mTogA;
    e.pb  = mDisB ? 1'b0 : mTogB;
    e.fl  = mFlags;
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] ad, input logic [15:0] dt, input string tag);
    step(1'b0, 1'b1, ad, dt, tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 3'd0, 16'h0, tag);
  endtask

  // monitor: compare each expected item after its clock edge
  always begin
    exp_t e;
    string t;
    @(posedge clk);
    #2;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      vectors++;
      if (count !== e.cnt || pinA !== e.pa || pinB !== e.pb || flags !== e.fl) begin
        fails++;
        $display("FAIL %s cnt/pinA/pinB/flags act=%h/%b/%b/%b exp=%h/%b/%b/%b",
                 t, count, pinA, pinB, flags, e.cnt, e.pa, e.pb, e.fl);
      end
    end
  end

  initial begin
    #(1_500_000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    step(1'b0, 1'b0, 3'd0, 16'h0, "R1_reset");
    run(3, "R2_stopped_ticks");
    // two edges per pin per cleared period
    wr(3'd0, 16'd9, "R10");
    wr(3'd2, 16'd4, "R10");
    wr(3'd1, 16'd6, "R10");
    wr(3'd3, 16'd2, "R10");
    wr(3'd4, 16'h0083, "R11_R3");
    run(25, "R3_R4_R5");
    // sparse ticks
    for (int i = 0; i < 12; i++) step(i[0], 1'b0, 3'd0, 16'h0, "R2_sparse");
    // coinciding compares on each pin
    wr(3'd2, 16'd9, "R4_same_tick");
    wr(3'd3, 16'd6, "R5_same_tick");
    run(22, "R4_R5_single");
    // initial levels
    wr(3'd4, 16'h0099, "R6_init");
    step(1'b0, 1'b0, 3'd0, 16'h0, "R6_hold");
    run(12, "R6");
    // flags: keep writes of 1, clear with 0 while matches occur
    wr(3'd5, 16'h000F, "R7_keep");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 3'd5, 16'h0, "R7_set_wins");
    wr(3'd5, 16'h0000, "R7_clear");
    // pin masking
    wr(3'd4, 16'h0063, "R8_mask");
    run(15, "R8");
    wr(3'd4, 16'h0003, "R8_unmask");
    run(8, "R8_state");
    // immediate compare change mid run
    wr(3'd1, 16'd1, "R10_change");
    run(12, "R10");
    // stop on A, no clear
    wr(3'd0, 16'd5, "R9");
    wr(3'd4, 16'h0085, "R9_start");
    run(10, "R9_stop");
    wr(3'd4, 16'h0081, "R9_nostop");
    run(10, "R9_keep");
    // wrap through FFFFH
    for (int i = 0; i < 4; i++) wr(3'(i), 16'hFFFE, "R2_wrap_cfg");
    wr(3'd4, 16'h0081, "R2_wrap_start");
    run(65540, "R2_wrap");
    wr(3'd4, 16'h0081, "R11_zero");
    step(1'b0, 1'b0, 3'd0, 16'h0, "R11");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule